// File: doc/BRIEF.md
# Periodic Tick Interrupt Generator

This block gives a time-slicing operating system a steady heartbeat. It counts cycles of a fixed reference clock up to a programmable terminal value, which sets the period. With the divisor trimmed for the reference clock, the block produces roughly ten ticks per second. Each tick latches a pending request. The request appears as a low level on one of eight active-low vectored interrupt lines, chosen by a 3-bit select. Every other line stays released at the high level.

The request stays pending until software deals with it. It is cleared either by an interrupt acknowledge strobe or by a strobe from an access to the tick-reset port. The port strobe also restarts the period from zero, so software can re-phase the tick. A bus error input raises the same request without disturbing the period. An indicator output flips its level on every periodic tick so that activity is visible.

All pins are plain control pins. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure rules.

Top module: `tick_irq_gen`

## Requirements
- R1: The period counter starts at zero after reset and advances once per clock. When it reaches the value on `divisor` (D), a tick fires and the counter returns to zero. The first tick therefore lands on the (D+1)-th rising edge after reset is released, and later ticks follow every D+1 edges. D = 0 ticks on every edge.
- R2: A tick sets a pending request. The request stays set across any number of cycles until it is cleared.
- R3: While a request is pending, only the line `irq_n[line_sel]` is driven low (0). All other lines are high (1). A change of `line_sel` moves the request to the new line at once, with no clock edge needed.
- R4: An edge with `ack` high clears the pending request, unless a set occurs on the same edge.
- R5: An edge with `port_clr` high clears the pending request and returns the period counter to zero. The next tick then comes D+1 edges later.
- R6: An edge with `bus_err` high sets the pending request. It leaves the period counter and `tick_led` unchanged.
- R7: `tick_led` inverts on every periodic tick and on nothing else. It is 0 after reset.
- R8: When a set (tick or bus error) and a clear (`ack` or `port_clr`) fall on the same edge, the set wins and the request stays pending.
- R9: An active-low asynchronous reset (`rst_n` = 0) forces all eight lines high, forces `tick_led` to 0 and sets the period counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| divisor | input | CNT_W | Terminal count; period is divisor+1 clocks |
| ack | input | 1 | Interrupt acknowledge strobe, clears request |
| port_clr | input | 1 | Tick-reset port strobe, clears request and restarts period |
| bus_err | input | 1 | Bus error, raises request |
| line_sel | input | 3 | Index of the vectored line that carries the request |
| irq_n | output | 8 | Active-low request lines; unselected lines held high |
| tick_led | output | 1 | Indicator, inverts on each periodic tick |

## Verification
The collision that matters is a periodic tick and a clearing strobe on the same edge. Left unresolved, that collision would silently lose one tick. The bench provokes it in two ways. In one run, `ack` is aligned with the edge on which a counter with divisor 3 reaches its terminal value. In another, a divisor of zero makes every edge a tick, and `ack` is applied on one of them. In both runs the request must still be low on the selected line afterwards. Port-clear timing is also judged by counting edges from the strobe to the next tick. The check shows that the period restarts from zero rather than continuing from where it was.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned SEL_W = $clog2(LINES);
  typedef logic [SEL_W-1:0] line_sel_t;
  typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] divisor,
  input  logic             restart,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  // ">=" keeps the count bounded if the divisor is lowered mid-period
  assign tick = (cnt_q >= divisor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tick_pending.sv
module tick_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bus_err,
  input  logic ack,
  input  logic port_clr,
  output logic pending,
  output logic led
);
  logic set_req, clr_req;

  assign set_req = tick | bus_err;
  assign clr_req = ack | port_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      led     <= 1'b0;
    end else begin
      if (set_req)      pending <= 1'b1;
      else if (clr_req) pending <= 1'b0;
      if (tick)         led <= ~led;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import tick_irq_pkg::*;
(
  input  logic      pending,
  input  line_sel_t line_sel,
  output line_vec_t irq_n
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign irq_n[i] = ~(pending && (line_sel == SEL_W'(i)));
  end
endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen
  import tick_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] divisor,
  input  logic             ack,
  input  logic             port_clr,
  input  logic             bus_err,
  input  logic [2:0]       line_sel,
  output logic [7:0]       irq_n,
  output logic             tick_led
);
  logic tick_w;
  logic pending_w;

  tick_divider #(.CNT_W(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .divisor (divisor),
    .restart (port_clr),
    .tick    (tick_w)
  );

  tick_pending u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .bus_err  (bus_err),
    .ack      (ack),
    .port_clr (port_clr),
    .pending  (pending_w),
    .led      (tick_led)
  );

  irq_router u_route (
    .pending  (pending_w),
    .line_sel (line_sel),
    .irq_n    (irq_n)
  );
endmodule

// File: rtl/tick_irq_chk.sv
module tick_irq_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] divisor,
  input logic             ack,
  input logic             port_clr,
  input logic             bus_err,
  input logic [2:0]       line_sel,
  input logic [7:0]       irq_n,
  input logic             tick_led,
  input logic             tick
);
  AST_AT_MOST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~irq_n)); // R3
  AST_ROUTE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n != 8'hFF) |-> (irq_n[line_sel] == 1'b0)); // R3
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n != 8'hFF && !ack && !port_clr) |=> (irq_n != 8'hFF)); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !bus_err && !tick) |=> (irq_n == 8'hFF)); // R4
  AST_PORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (port_clr && divisor != '0) |=> !tick); // R5
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> (irq_n != 8'hFF)); // R6
  AST_LED_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (tick_led != $past(tick_led))); // R7
  AST_LED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tick_led)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((tick || bus_err) && (ack || port_clr)) |=> (irq_n != 8'hFF)); // R8
endmodule

bind tick_irq_gen tick_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .divisor  (divisor),
  .ack      (ack),
  .port_clr (port_clr),
  .bus_err  (bus_err),
  .line_sel (line_sel),
  .irq_n    (irq_n),
  .tick_led (tick_led),
  .tick     (tick_w)
);

// File: tb/tick_irq_gen_bench.sv
module tick_irq_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] divisor = '0;
  logic        ack = 1'b0, port_clr = 1'b0, bus_err = 1'b0;
  logic [2:0]  line_sel = '0;
  logic [7:0]  irq_n;
  logic        tick_led;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  tick_irq_gen #(.CNT_W(24)) u_tick_irq_gen (
    .clk, .rst_n, .divisor, .ack, .port_clr, .bus_err,
    .line_sel, .irq_n, .tick_led
  );

  // divisor, select, irq_n after first tick, irq_n after ack on next edge
  localparam logic [31:0] VEC [5][4] = '{
    '{32'd4,  32'd0, 32'hFE, 32'hFF},
    '{32'd9,  32'd3, 32'hF7, 32'hFF},
    '{32'd0,  32'd7, 32'h7F, 32'h7F},
    '{32'd2,  32'd5, 32'hDF, 32'hFF},
    '{32'd15, 32'd1, 32'hFD, 32'hFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ack = 1'b0; port_clr = 1'b0; bus_err = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9 reset state
    @(negedge clk);
    check("R9 lines in reset", irq_n, 8'hFF);
    check("R9 led in reset", tick_led, 0);

    // Table walk: R1 period, R2/R3 routing, R4 ack, R8 with D=0
    for (int k = 0; k < 5; k++) begin
      divisor  = VEC[k][0][23:0];
      line_sel = VEC[k][1][2:0];
      do_reset();
      if (VEC[k][0] > 0) step(VEC[k][0]);
      check("R1 no tick before period", irq_n, 8'hFF);
      step(1);
      check("R1 R3 tick on selected line", irq_n, VEC[k][2]);
      check("R7 led after first tick", tick_led, 1);
      ack = 1'b1;
      step(1);
      ack = 1'b0;
      check("R4 R8 after ack", irq_n, VEC[k][3]);
    end

    // R5 port clear restarts period and clears request
    divisor = 24'd9; line_sel = 3'd2;
    do_reset();
    step(5);
    port_clr = 1'b1; step(1); port_clr = 1'b0;
    step(9);
    check("R5 period restarted", irq_n, 8'hFF);
    step(1);
    check("R5 tick after full period", irq_n, 8'hFB);
    port_clr = 1'b1; step(1); port_clr = 1'b0;
    check("R5 port clear releases", irq_n, 8'hFF);

    // R6 bus error raises request, led untouched; R2 held; R3 reroute
    divisor = 24'd1000; line_sel = 3'd6;
    do_reset();
    step(3);
    bus_err = 1'b1; step(1); bus_err = 1'b0;
    check("R6 bus error raises", irq_n, 8'hBF);
    check("R6 led unchanged", tick_led, 0);
    step(2);
    check("R2 request held", irq_n, 8'hBF);
    line_sel = 3'd1; #1;
    check("R3 reroute", irq_n, 8'hFD);
    @(negedge clk);
    ack = 1'b1; step(1); ack = 1'b0;
    check("R4 ack clears error request", irq_n, 8'hFF);

    // R8 tick and ack on the same edge
    divisor = 24'd3; line_sel = 3'd4;
    do_reset();
    step(3);
    ack = 1'b1; step(1); ack = 1'b0;
    check("R8 set wins over ack", irq_n, 8'hEF);

    // R9 reset while pending
    rst_n = 1'b0; #1;
    check("R9 reset releases lines", irq_n, 8'hFF);
    check("R9 reset clears led", tick_led, 0);

    // R7 led inverts each tick
    divisor = 24'd2; line_sel = 3'd0;
    do_reset();
    step(3);
    check("R7 led first tick", tick_led, 1);
    step(3);
    check("R7 led second tick", tick_led, 0);

    finish_run();
  end
endmodule